// File: doc/BRIEF.md
# Sixteen-Bit Bus I/O Port

This block places a sixteen-bit parallel port on an AT-class expansion bus. It watches the ten low I/O address lines and the DMA address-enable line, and claims a window of four 16-bit registers at a base address fixed by a parameter. While the window is addressed it raises an enable for an external open-collector pull-down on the 16-bit I/O chip-select line. The host then runs one full-width I/O cycle instead of two slow byte cycles with extra wait states.

The registers hold an output latch, a per-bit direction mask and a view of the external pins. A host write is taken on the rising edge of the write strobe. A host read puts the addressed register onto the bus through a separate output enable, so the bus buffer is only turned toward the host during a matched read. All bus strobes are sampled on a local clock, and reset is synchronous and active high.

Top module: `isa16_io_port`

## Requirements
- R1: The port is selected only while `aen` is 0 and `bus_addr[9:3]` equals `BASE[9:3]`. `bus_addr[0]` plays no part, and `bus_addr[2:1]` only picks the register: 0 = output latch, 1 = pin view, 2 = direction mask, 3 = reserved.
- R2: `cs16_pull_low` is 1 exactly while the port is selected and reset is low. It is a pull-down enable only, and it is 0 whenever `aen` is 1.
- R3: `bus_rdata_oe` is 1 only while the port is selected and `ior_n` is 0. At all other times it is 0 and `bus_rdata` reads 0.
- R4: Suppose `iow_n` is sampled high on a clock edge after it was sampled low on the previous edge, the port is selected and the register index is 0. Then `bus_wdata` is stored in the output latch at that edge.
- R5: The same write strobe with register index 2 stores `bus_wdata` into the direction mask.
- R6: `pin_out` always equals the output latch, and `pin_drive[i]` equals direction bit i (1 = driven).
- R7: A read of index 0 returns the output latch, and a read of index 2 returns the direction mask. A read of index 1 returns, for each bit, the latch bit where direction is 1 and `pin_in` where it is 0. A read of index 3 returns 0.
- R8: Write strobes to index 1 or 3, write strobes while the port is not selected, and held-low `iow_n` change neither the latch nor the direction mask.
- R9: Reset clears the latch and the direction mask to 0 and forces `cs16_pull_low` and `bus_rdata_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 10 | Low I/O address lines |
| bus_wdata | input | 16 | Data bus as driven by the host |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| aen | input | 1 | DMA address enable, high during DMA |
| pin_in | input | 16 | Level seen on the external pins |
| bus_rdata | output | 16 | Data returned to the host |
| bus_rdata_oe | output | 1 | Turns the bus buffer toward the host |
| cs16_pull_low | output | 1 | Enable of the open-collector pull-down on the 16-bit chip-select |
| pin_out | output | 16 | Output latch to the pin drivers |
| pin_drive | output | 16 | Per-pin driver enable |

## Verification
The assertions take for granted that the host holds address, `aen` and write data steady from before a write strobe falls until at least one clock after it rises. This matters because the write is taken at the edge that first sees `iow_n` high. They also assume the read and write strobes are never low together. The bench drives every cycle through tasks that keep to this order: it sets up the address one half clock ahead, holds it one clock past the strobe release, and never overlaps the strobes. Random addresses are drawn both inside and outside the window, and with `aen` either level, so that hits and misses both occur.

// File: rtl/isa16_pkg.sv
package isa16_pkg;

    localparam int ADDR_W   = 10;
    localparam int NUM_REGS = 4;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int WIN_LSB  = IDX_W + 1;

    typedef enum logic [IDX_W-1:0] {
        REG_LATCH = 2'd0,
        REG_PINS  = 2'd1,
        REG_DIR   = 2'd2,
        REG_RSVD  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic     sel;
        logic     rd;
        logic     wr_stb;
        reg_idx_e idx;
    } bus_req_t;

    function automatic logic window_hit(
        input logic [ADDR_W-1:0] a,
        input logic              aen_i,
        input logic [ADDR_W-1:0] base
    );
        return !aen_i && (a[ADDR_W-1:WIN_LSB] == base[ADDR_W-1:WIN_LSB]);
    endfunction

endpackage

// File: rtl/isa16_decode.sv
module isa16_decode
    import isa16_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 10'h300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:1] addr_hi,
    input  logic              aen,
    input  logic              ior_n,
    input  logic              iow_n,
    output bus_req_t          req
);
    logic iow_q;

    always_ff @(posedge clk) begin
        if (rst) iow_q <= 1'b1;
        else     iow_q <= iow_n;
    end

    always_comb begin
        req.sel    = window_hit({addr_hi, 1'b0}, aen, BASE);
        req.idx    = reg_idx_e'(addr_hi[IDX_W:1]);
        req.rd     = req.sel && !ior_n;
        req.wr_stb = req.sel && iow_n && !iow_q;
    end

    assert_no_dma_select_R1: assert property (@(posedge clk) disable iff (rst)
        aen |-> !req.sel);

    assert_strobe_after_low_R4: assert property (@(posedge clk) disable iff (rst)
        req.wr_stb |-> $past(!iow_n));

endmodule

// File: rtl/isa16_port_regs.sv
module isa16_port_regs
    import isa16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] latch_q,
    output logic [DATA_W-1:0] dir_q
);
    logic wr_latch, wr_dir;

    assign wr_latch = req.wr_stb && (req.idx == REG_LATCH);
    assign wr_dir   = req.wr_stb && (req.idx == REG_DIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            if (wr_latch) latch_q <= wdata;
            if (wr_dir)   dir_q   <= wdata;
        end
    end

    assert_latch_write_R4: assert property (@(posedge clk) disable iff (rst)
        (req.wr_stb && req.idx == REG_LATCH) |=> (latch_q == $past(wdata)));

    assert_dir_write_R5: assert property (@(posedge clk) disable iff (rst)
        (req.wr_stb && req.idx == REG_DIR) |=> (dir_q == $past(wdata)));

    assert_hold_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !req.wr_stb |=> ($stable(latch_q) && $stable(dir_q)));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (latch_q == '0 && dir_q == '0));

endmodule

// File: rtl/isa16_read_mux.sv
module isa16_read_mux
    import isa16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] latch_q,
    input  logic [DATA_W-1:0] dir_q,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] pin_view;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pin
        assign pin_view[i] = dir_q[i] ? latch_q[i] : pin_in[i];
    end

    always_comb begin
        unique case (idx)
            REG_LATCH: rdata = latch_q;
            REG_PINS:  rdata = pin_view;
            REG_DIR:   rdata = dir_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/isa16_io_port.sv
module isa16_io_port
    import isa16_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE   = 10'h300,
    parameter int                DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic              aen,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    output logic              cs16_pull_low,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_drive
);
    bus_req_t          req;
    logic [DATA_W-1:0] latch_q, dir_q, mux_data;
    logic              unused_a0;

    assign unused_a0 = bus_addr[0];

    isa16_decode #(.BASE(BASE)) u_decode (
        .clk     (clk),
        .rst     (rst),
        .addr_hi (bus_addr[ADDR_W-1:1]),
        .aen     (aen),
        .ior_n   (ior_n),
        .iow_n   (iow_n),
        .req     (req)
    );

    isa16_port_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    isa16_read_mux #(.DATA_W(DATA_W)) u_mux (
        .idx     (req.idx),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pin_in  (pin_in),
        .rdata   (mux_data)
    );

    assign cs16_pull_low = req.sel && !rst;
    assign bus_rdata_oe  = req.rd && !rst;
    assign bus_rdata     = bus_rdata_oe ? mux_data : '0;
    assign pin_out       = latch_q;
    assign pin_drive     = dir_q;

    assert_pull_not_dma_R2: assert property (@(posedge clk) disable iff (rst)
        cs16_pull_low |-> !aen);

    assert_oe_needs_read_R3: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_oe |-> (!ior_n && cs16_pull_low));

    assert_reset_release_R9: assert property (@(posedge clk)
        rst |-> (!cs16_pull_low && !bus_rdata_oe));

endmodule

// File: tb/tb_isa16_io_port.sv
module tb_isa16_io_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] BASE = 10'h300;

    logic        clk = 1'b0, rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, pin_in = '0;
    logic        ior_n = 1'b1, iow_n = 1'b1, aen = 1'b0;
    logic [15:0] bus_rdata, pin_out, pin_drive;
    logic        bus_rdata_oe, cs16_pull_low;

    int checks = 0, errors = 0;
    logic [15:0] m_lat = '0, m_dir = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa16_io_port #(.BASE(BASE), .DATA_W(16)) dut (.*);

    function automatic bit exp_sel(input logic [9:0] a, input logic e);
        return !e && (a[9:3] == BASE[9:3]);
    endfunction

    function automatic logic [15:0] exp_read(input logic [9:0] a, input logic [15:0] pins);
        case (a[2:1])
            2'd0: return m_lat;
            2'd1: return (m_dir & m_lat) | (~m_dir & pins);
            2'd2: return m_dir;
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [9:0] a, input logic e, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; aen = e; bus_wdata = d; iow_n = 1'b0;
        @(negedge clk);
        check("R2 pull during write", cs16_pull_low, exp_sel(a, e));
        check("R3 no oe on write", bus_rdata_oe, 1'b0);
        iow_n = 1'b1;
        @(negedge clk);
        if (exp_sel(a, e) && a[2:1] == 2'd0) m_lat = d;
        if (exp_sel(a, e) && a[2:1] == 2'd2) m_dir = d;
        check("R4/R8 latch", pin_out, m_lat);
        check("R5/R6 direction", pin_drive, m_dir);
        bus_addr = 10'h0; aen = 1'b0;
    endtask

    task automatic io_read(input logic [9:0] a, input logic e, input logic [15:0] pins);
        @(negedge clk);
        bus_addr = a; aen = e; pin_in = pins; ior_n = 1'b0;
        #1;
        check("R1/R2 select", cs16_pull_low, exp_sel(a, e));
        check("R3 oe", bus_rdata_oe, exp_sel(a, e));
        check("R7 rdata", bus_rdata, exp_sel(a, e) ? exp_read(a, pins) : 16'h0);
        @(negedge clk);
        ior_n = 1'b1;
        #1;
        check("R3 oe released", bus_rdata_oe, 1'b0);
        bus_addr = 10'h0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        bus_addr = BASE;
        #1;
        check("R9 pull in reset", cs16_pull_low, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 latch reset", pin_out, 16'h0);
        check("R9 dir reset", pin_drive, 16'h0);
        check("R2 pull after reset", cs16_pull_low, 1'b1);

        // directed
        io_write(BASE, 1'b0, 16'hA5C3);          // R4
        io_write(BASE | 10'd1, 1'b0, 16'h1234);  // R1 A0 ignored
        io_write(BASE | 10'd4, 1'b0, 16'hFF00);  // R5
        io_read(BASE | 10'd2, 1'b0, 16'h0F0F);   // R7 pin view
        io_read(BASE | 10'd6, 1'b0, 16'hFFFF);   // R7 reserved
        io_write(BASE | 10'd2, 1'b0, 16'hDEAD);  // R8 pins ignored
        io_write(BASE | 10'd6, 1'b0, 16'hBEEF);  // R8 reserved ignored
        io_write(BASE, 1'b1, 16'h5555);          // R1 DMA ignored
        io_write(BASE ^ 10'h008, 1'b0, 16'h7777); // R8 miss ignored
        io_read(BASE, 1'b1, 16'h0);              // R2 no pull on DMA
        io_read(BASE, 1'b0, 16'h0);              // R7 latch
        io_read(BASE | 10'd4, 1'b0, 16'h0);      // R7 dir

        // held-low strobe: no write until release (R8)
        @(negedge clk);
        bus_addr = BASE; bus_wdata = 16'h0BAD; iow_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 held strobe", pin_out, m_lat);
        iow_n = 1'b1;
        @(negedge clk);
        m_lat = 16'h0BAD;
        check("R4 release write", pin_out, m_lat);

        // random
        for (int i = 0; i < 300; i++) begin
            logic [9:0] a;
            logic e;
            a = ($urandom_range(0, 3) != 0) ? (BASE | 10'($urandom_range(0, 7)))
                                            : 10'($urandom);
            e = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 1) == 1) io_write(a, e, 16'($urandom));
            else                           io_read(a, e, 16'($urandom));
        end

        // reset mid-state
        @(negedge clk);
        rst = 1'b1; bus_addr = BASE; ior_n = 1'b0;
        #1;
        check("R9 oe in reset", bus_rdata_oe, 1'b0);
        @(negedge clk);
        ior_n = 1'b1; rst = 1'b0; m_lat = '0; m_dir = '0;
        check("R9 latch cleared", pin_out, 16'h0);
        check("R9 dir cleared", pin_drive, 16'h0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule